// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a synchronous two-port memory, 4096 words of 16 bits by default. The left and right ports are identical. Each port has an enable, a write select, an address, write data, registered read data, a BUSY output and a BUSY input. Both ports may reach any word in the same cycle. When both are enabled on the same word, a collision arbiter gives the word to the port that claimed it first. It raises BUSY toward the other port and vetoes that port's writes until the collision ends.

A mode input picks master or slave operation. In master mode the block arbitrates itself and drives its BUSY outputs. In slave mode the internal arbiter is idle and the BUSY outputs stay low. Each port's BUSY input then acts as an external write inhibit. This lets a second block slave its write gating to an arbiter that sits elsewhere.

The ports are plain single-cycle request interfaces, not valid/ready streams. An enabled port is served in the cycle it is presented. The only back-pressure is BUSY. A port that sees BUSY keeps its write request applied until BUSY drops, and the write then lands.

Top module: `dual_port_arbitrated_ram`

## Requirements
- R1: Both ports use the same address and data widths. By default there are 4096 words of 16 bits. A port with enable=1 and write select=0 returns the addressed word on its read data one clock later. The word returned is the one held before any write at that same edge. Read data holds its value when the port does not read.
- R2: A BUSY output is 1 only in the cycle after one in which both enables were 1 and both addresses were equal.
- R3: A claim is new in a cycle when its port is enabled and either was disabled or held another address in the previous cycle. When a collision begins and only one port's claim is new, the port with the older claim wins and the BUSY output of the new port goes to 1. This covers both ways a collision can begin: through an address change or through an enable rising.
- R4: If both claims are new in the cycle the collision begins, the left port wins and the right BUSY output goes to 1.
- R5: In master mode a port's write does not change memory in two cases: in the cycle its collision begins, if that port lost; and in any cycle in which its BUSY output is 1.
- R6: BUSY outputs drop to 0 one cycle after the addresses differ or either enable is 0.
- R7: A write that was held off lands in the first cycle in which its port's BUSY output reads 0, provided the request is still applied.
- R8: A port whose BUSY output is 1 still reads, and gets the current memory contents.
- R9: The winner is held for the whole collision, and the two BUSY outputs are never 1 together.
- R10: With slave_mode=1 both BUSY outputs read 0 from the next cycle on, and no arbitration takes place. A port's write is dropped while its BUSY input is 1. If both ports write the same word in one cycle, the left data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1 = external BUSY inputs gate writes, 0 = internal arbitration |
| lft_en | input | 1 | Left port enable, active high |
| lft_wr | input | 1 | Left write select (1 write, 0 read) |
| lft_addr | input | ADDR_W | Left word address |
| lft_wdata | input | DATA_W | Left write data |
| lft_rdata | output | DATA_W | Left registered read data |
| lft_busy_in | input | 1 | Left external write inhibit (slave mode) |
| lft_busy_out | output | 1 | Left registered BUSY (master mode) |
| rgt_en | input | 1 | Right port enable, active high |
| rgt_wr | input | 1 | Right write select (1 write, 0 read) |
| rgt_addr | input | ADDR_W | Right word address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_rdata | output | DATA_W | Right registered read data |
| rgt_busy_in | input | 1 | Right external write inhibit (slave mode) |
| rgt_busy_out | output | 1 | Right registered BUSY (master mode) |

## Verification
The bench targets these corner cases:
- A late writer arriving by address change and by enable rise, with the left and right roles swapped. A design that got this backwards would flag the wrong side or let the loser overwrite the word.
- A tie in which both ports claim the same word in one cycle. A design without a fixed tie-break would flag both sides or neither.
- A collision that is held for several cycles. A design whose winner can flip would hand the word over in mid-collision.
- The release cycle, where a held write must wait for BUSY to fall and then land exactly once. A design without the veto from the registered BUSY would let the write in one cycle early.
- Slave mode, where a design that kept arbitrating would drive BUSY or ignore the external inhibit.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int SIDE_LEFT  = 0;
  localparam int SIDE_RIGHT = 1;
  localparam int NUM_SIDES  = 2;
endpackage

// File: rtl/dpr_claim_tracker.sv
// Remembers last cycle's claim of one port and flags a newly arrived claim.
module dpr_claim_tracker #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  assign fresh = en && (!prev_en || (prev_addr != addr));
endmodule

// File: rtl/dpr_collision_arbiter.sv
// Decides ownership of a shared word and registers the BUSY flags.
module dpr_collision_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic [1:0]        en,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [1:0]        fresh,
  output logic [1:0]        lose_now,
  output logic [1:0]        busy_q
);
  owner_e owner_q, owner_d;
  logic   match;

  assign match = en[SIDE_LEFT] && en[SIDE_RIGHT] && (addr_l == addr_r);

  always_comb begin
    owner_d = OWN_NONE;
    if (!slave_mode && match) begin
      if (owner_q != OWN_NONE)
        owner_d = owner_q;
      else if (fresh[SIDE_LEFT] && !fresh[SIDE_RIGHT])
        owner_d = OWN_RIGHT;
      else
        owner_d = OWN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assign lose_now[SIDE_LEFT]  = (owner_d == OWN_RIGHT);
  assign lose_now[SIDE_RIGHT] = (owner_d == OWN_LEFT);
  assign busy_q[SIDE_LEFT]    = (owner_q == OWN_RIGHT);
  assign busy_q[SIDE_RIGHT]   = (owner_q == OWN_LEFT);
endmodule

// File: rtl/dpr_write_gate.sv
// Per-port write permission from the internal or the external BUSY.
module dpr_write_gate (
  input  logic slave_mode,
  input  logic en,
  input  logic wr,
  input  logic busy_int,
  input  logic lose_now,
  input  logic busy_ext,
  output logic wr_ok
);
  logic blocked;

  assign blocked = slave_mode ? busy_ext : (busy_int || lose_now);
  assign wr_ok   = en && wr && !blocked;
endmodule

// File: rtl/dpr_storage.sv
// Two-port word array; read-first, left write applied last on a clash.
module dpr_storage #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rd_en,
  input  logic [1:0]        we,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wdata_l,
  input  logic [DATA_W-1:0] wdata_r,
  output logic [DATA_W-1:0] rdata_l,
  output logic [DATA_W-1:0] rdata_r
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we[1]) mem[addr_r] <= wdata_r;
    if (we[0]) mem[addr_l] <= wdata_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_l <= '0;
      rdata_r <= '0;
    end else begin
      if (rd_en[0]) rdata_l <= mem[addr_l];
      if (rd_en[1]) rdata_r <= mem[addr_r];
    end
  end
endmodule

// File: rtl/dual_port_arbitrated_ram.sv
module dual_port_arbitrated_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              lft_en,
  input  logic              lft_wr,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic [DATA_W-1:0] lft_wdata,
  output logic [DATA_W-1:0] lft_rdata,
  input  logic              lft_busy_in,
  output logic              lft_busy_out,
  input  logic              rgt_en,
  input  logic              rgt_wr,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic [DATA_W-1:0] rgt_wdata,
  output logic [DATA_W-1:0] rgt_rdata,
  input  logic              rgt_busy_in,
  output logic              rgt_busy_out
);
  logic [NUM_SIDES-1:0] en_v, wr_v, bext_v, fresh_v, lose_v, busy_v, we_v, rd_v;
  logic [ADDR_W-1:0]    addr_v [NUM_SIDES];

  assign en_v   = {rgt_en, lft_en};
  assign wr_v   = {rgt_wr, lft_wr};
  assign bext_v = {rgt_busy_in, lft_busy_in};
  assign addr_v[SIDE_LEFT]  = lft_addr;
  assign addr_v[SIDE_RIGHT] = rgt_addr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dpr_claim_tracker #(.ADDR_W(ADDR_W)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_v[s]),
      .addr  (addr_v[s]),
      .fresh (fresh_v[s])
    );

    dpr_write_gate u_gate (
      .slave_mode (slave_mode),
      .en         (en_v[s]),
      .wr         (wr_v[s]),
      .busy_int   (busy_v[s]),
      .lose_now   (lose_v[s]),
      .busy_ext   (bext_v[s]),
      .wr_ok      (we_v[s])
    );

    assign rd_v[s] = en_v[s] && !wr_v[s];
  end

  dpr_collision_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .en         (en_v),
    .addr_l     (lft_addr),
    .addr_r     (rgt_addr),
    .fresh      (fresh_v),
    .lose_now   (lose_v),
    .busy_q     (busy_v)
  );

  dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_v),
    .we      (we_v),
    .addr_l  (lft_addr),
    .addr_r  (rgt_addr),
    .wdata_l (lft_wdata),
    .wdata_r (rgt_wdata),
    .rdata_l (lft_rdata),
    .rdata_r (rgt_rdata)
  );

  assign lft_busy_out = busy_v[SIDE_LEFT];
  assign rgt_busy_out = busy_v[SIDE_RIGHT];
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              lft_en,
  input logic [ADDR_W-1:0] lft_addr,
  input logic              lft_busy_out,
  input logic              rgt_en,
  input logic [ADDR_W-1:0] rgt_addr,
  input logic              rgt_busy_out
);
  logic match;
  assign match = lft_en && rgt_en && (lft_addr == rgt_addr);

  assert_one_loser_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lft_busy_out && rgt_busy_out));

  assert_left_busy_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lft_busy_out) |-> $past(match));

  assert_right_busy_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rgt_busy_out) |-> $past(match));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> (!lft_busy_out && !rgt_busy_out));

  assert_hold_right_loser_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && rgt_busy_out && match) |=> rgt_busy_out);

  assert_hold_left_loser_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && lft_busy_out && match) |=> lft_busy_out);

  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |=> (!lft_busy_out && !rgt_busy_out));
endmodule

bind dual_port_arbitrated_ram dpr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slave_mode   (slave_mode),
  .lft_en       (lft_en),
  .lft_addr     (lft_addr),
  .lft_busy_out (lft_busy_out),
  .rgt_en       (rgt_en),
  .rgt_addr     (rgt_addr),
  .rgt_busy_out (rgt_busy_out)
);

// File: tb/sim_dual_port_arbitrated_ram.sv
`timescale 1ns/1ps
module sim_dual_port_arbitrated_ram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slv = 1'b0;
  logic le = 0, lw = 0, lbi = 0, re = 0, rw = 0, rbi = 0;
  logic [AW-1:0] la = '0, ra = '0;
  logic [DW-1:0] ld = '0, rd = '0;
  logic [DW-1:0] lq, rq;
  logic lbo, rbo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] mem_m [4096];
  int  own_m = 0;            // 0 none, 1 left holds word, 2 right holds word
  bit  pen_l = 0, pen_r = 0;
  logic [AW-1:0] pa_l = '0, pa_r = '0;
  logic [DW-1:0] exp_lq = '0, exp_rq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_arbitrated_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .slave_mode(slv),
    .lft_en(le), .lft_wr(lw), .lft_addr(la), .lft_wdata(ld), .lft_rdata(lq),
    .lft_busy_in(lbi), .lft_busy_out(lbo),
    .rgt_en(re), .rgt_wr(rw), .rgt_addr(ra), .rgt_wdata(rd), .rgt_rdata(rq),
    .rgt_busy_in(rbi), .rgt_busy_out(rbo)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one clock: advance the reference, then compare every output
  task automatic cyc(string tag);
    bit m, lnew, rnew, okl, okr;
    int own_n;
    m    = le && re && (la == ra);
    lnew = le && (!pen_l || pa_l != la);
    rnew = re && (!pen_r || pa_r != ra);
    if (slv) begin
      own_n = 0;
      okl = le && lw && !lbi;
      okr = re && rw && !rbi;
    end else begin
      if (!m)             own_n = 0;
      else if (own_m != 0) own_n = own_m;
      else if (lnew && !rnew) own_n = 2;
      else                own_n = 1;
      okl = le && lw && own_m != 2 && own_n != 2;
      okr = re && rw && own_m != 1 && own_n != 1;
    end
    if (le && !lw) exp_lq = mem_m[la];
    if (re && !rw) exp_rq = mem_m[ra];
    if (okr) mem_m[ra] = rd;
    if (okl) mem_m[la] = ld;
    own_m = own_n;
    pen_l = le; pa_l = la; pen_r = re; pa_r = ra;
    @(posedge clk);
    #1;
    chk(tag, "left busy",   {31'd0, lbo}, {31'd0, own_m == 2});
    chk(tag, "right busy",  {31'd0, rbo}, {31'd0, own_m == 1});
    chk(tag, "left rdata",  {16'd0, lq}, {16'd0, exp_lq});
    chk(tag, "right rdata", {16'd0, rq}, {16'd0, exp_rq});
  endtask

  task automatic idle();
    le = 0; lw = 0; re = 0; rw = 0; lbi = 0; rbi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1", "reset left rdata", {16'd0, lq}, 32'd0);
    chk("R2", "reset busy", {30'd0, lbo, rbo}, 32'd0);

    // R1: independent writes then reads on both ports
    le = 1; lw = 1; la = 12'd5;  ld = 16'h1111;
    re = 1; rw = 1; ra = 12'd6;  rd = 16'h2222; cyc("R1");
    le = 1; lw = 1; la = 12'd20; ld = 16'h2020;
    re = 1; rw = 1; ra = 12'd40; rd = 16'h4040; cyc("R1");
    lw = 0; la = 12'd6; rw = 0; ra = 12'd5; cyc("R1");
    idle(); cyc("R1");

    // R3 address trigger: left holds word 5, right moves onto it with a write
    le = 1; lw = 0; la = 12'd5; re = 1; rw = 0; ra = 12'd7; cyc("R3");
    rw = 1; ra = 12'd5; rd = 16'hBAD0; cyc("R5");     // collision begins, right loses
    cyc("R9"); cyc("R9");                             // held, write stays vetoed
    rw = 0; cyc("R8");                                // busy right port still reads
    rw = 1; la = 12'd6; cyc("R7");                    // left leaves, busy still high
    cyc("R7");                                        // busy low: held write lands
    rw = 0; cyc("R7");
    idle(); cyc("R6");

    // R3 enable trigger, mirrored: right holds word 20, left enables on it
    re = 1; rw = 0; ra = 12'd20; cyc("R3");
    le = 1; lw = 1; la = 12'd20; ld = 16'hDEAD; cyc("R3");
    cyc("R5");
    re = 0; cyc("R6");                                // right drops enable
    lw = 0; cyc("R6");
    idle(); cyc("R6");

    // R4 tie: both claim word 40 in the same cycle
    le = 1; lw = 1; la = 12'd40; ld = 16'hAAAA;
    re = 1; rw = 1; ra = 12'd40; rd = 16'hBBBB; cyc("R4");
    cyc("R4");
    lw = 0; cyc("R9");
    idle(); cyc("R6");
    re = 1; rw = 0; ra = 12'd40; cyc("R4");
    idle(); cyc("R4");

    // R10 slave mode
    slv = 1;
    le = 1; lw = 1; la = 12'd30; ld = 16'h3030; lbi = 1;
    re = 1; rw = 1; ra = 12'd30; rd = 16'h0303; cyc("R10");
    lbi = 0; rbi = 1; ld = 16'h3131; cyc("R10");
    rbi = 0; la = 12'd31; ra = 12'd31; ld = 16'h5151; rd = 16'h6161; cyc("R10");
    lw = 0; rw = 0; cyc("R10");
    la = 12'd30; ra = 12'd30; cyc("R10");
    idle(); slv = 0; cyc("R10");

    // walk across many addresses with staggered collisions
    for (int k = 0; k < 60; k++) begin
      le = 1; lw = k[0]; la = AW'(k % 8); ld = DW'(k * 37);
      re = 1; rw = k[1]; ra = AW'((k + k / 3) % 8); rd = DW'(k * 91);
      cyc("R3");
    end
    idle(); cyc("R6");
    for (int k = 0; k < 8; k++) begin
      le = 1; lw = 0; la = AW'(k); cyc("R1");
    end
    idle(); cyc("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule